// File: doc/BRIEF.md
# Dual-Address Memory Protection Decoder

This block sits behind a two-wire serial slave front end that has already pulled the device address byte, the memory offset and the data bytes out of the bus. For each transaction it decides whether the device address is answered and which storage region each offset reaches. It also decides whether a write byte may change that storage, and it raises a commit strobe for nonvolatile storage once the bus stop condition arrives.

Two device addresses exist. The main address is fixed at A2h or, on request, taken from a programmable byte. The auxiliary address is A0h and can be switched off. Offsets at 80h and above on the main address are banked: a table-select byte picks the table. Write permission comes from two lock bits and a write-protect pin. A volatile window on the main address is always writable.

Top module: `dual_addr_guard`

## Requirements
- R1: The main address is A2h when cfg_fix_i is 0 and prog_addr_i when it is 1. It is answered in both modes. Bits 7:1 are compared, and bit 0 of the device byte is the direction (1 = read). dev_ack_o is combinational while dev_stb_i is high.
- R2: The auxiliary address A0h is answered only when cfg_single_i is 0. If both addresses match, the main address wins.
- R3: Main offsets below 80h map to region 1 (main low) with local_addr_o equal to the offset. Offsets of 80h and above use tbl_sel_i and give local_addr_o = offset - 80h. Table 0 maps to region 3 only when cfg_single_i is 1. Table 1 maps to region 4 and table 2 to region 5. Table 3 maps to region 2 (auxiliary space, lower half).
- R4: An access through the auxiliary address maps to region 2 with local_addr_o equal to the offset. Such writes are allowed only when cfg_aux_lock_i is 0. Writes to table 0 are allowed only when cfg_aux_lock_i is 0, whatever wp_i is.
- R5: Any other main-address write outside 60h..7Fh is refused when cfg_main_lock_i and wp_i are both 1. It is allowed when wp_i is 0.
- R6: Main-address offsets 60h..7Fh are always writable, whatever the lock bits or the pin are.
- R7: Every write byte of an answered write transaction gets data_ack_o, even when the write is refused. wr_en_o is raised only when the write is allowed. A read transaction gets neither signal.
- R8: commit_o pulses for one cycle, in the cycle after stop_i, when the transaction accepted at least one write outside the volatile window. Volatile-only transactions and refused writes give no commit.
- R9: Unimplemented tables (table 0 in dual mode, numbers above 3) give region 0 with blank_o = 1, so reads return FFh. Writes to them give wr_en_o = 0.
- R10: After reset, no transaction is active and commit_o is 0. Write bytes get no data_ack_o.
- R11: stop_i ends the transaction. A device byte that is not answered also ends it. Later write bytes get no data_ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_single_i | input | 1 | Single-address mode |
| cfg_fix_i | input | 1 | Main address taken from prog_addr_i |
| cfg_aux_lock_i | input | 1 | Locks auxiliary space and table 0 |
| cfg_main_lock_i | input | 1 | Locks main space while wp_i is high |
| prog_addr_i | input | 8 | Programmable main device address |
| tbl_sel_i | input | 8 | Table-select byte |
| wp_i | input | 1 | Write-protect pin |
| dev_stb_i | input | 1 | Device address byte valid |
| dev_byte_i | input | 8 | Device address byte, bit 0 = read |
| dev_ack_o | output | 1 | Device address answered |
| stop_i | input | 1 | Bus stop condition seen |
| wr_stb_i | input | 1 | Write data byte valid |
| mem_addr_i | input | 8 | Memory offset of current byte |
| data_ack_o | output | 1 | Write data byte acknowledged |
| wr_en_o | output | 1 | Write allowed to storage |
| region_o | output | 3 | Target region code |
| local_addr_o | output | 8 | Offset inside the region |
| blank_o | output | 1 | Unimplemented target, read as FFh |
| commit_o | output | 1 | Nonvolatile commit strobe |

## Verification
The assertions assume that dev_stb_i, wr_stb_i and stop_i are never high in the same cycle. They also assume that the configuration bits, tbl_sel_i and wp_i stay steady while a write byte is strobed. The bench follows both rules: each task raises exactly one strobe for one cycle, and it sets the configuration in a separate cycle before the strobe. Each transaction is closed with a stop before the mode bits change.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    RGN_NONE    = 3'd0,
    RGN_MAIN_LO = 3'd1,
    RGN_AUX     = 3'd2,
    RGN_TBL0    = 3'd3,
    RGN_TBL1    = 3'd4,
    RGN_TBL2    = 3'd5
  } rgn_e;
endpackage

// File: rtl/dag_dev_match.sv
module dag_dev_match #(
  parameter int AW = 8,
  parameter logic [AW-1:0] MAIN_DEF = 8'hA2,
  parameter logic [AW-1:0] AUX_ADDR = 8'hA0
) (
  input  logic          single_i,
  input  logic          fix_i,
  input  logic [AW-1:0] prog_i,
  input  logic [AW-1:0] byte_i,
  output logic          hit_main_o,
  output logic          hit_aux_o
);
  localparam logic [AW-1:0] CMP_MASK = {{(AW-1){1'b1}}, 1'b0};
  logic [AW-1:0] main_addr;

  always_comb begin
    main_addr  = fix_i ? prog_i : MAIN_DEF;
    hit_main_o = ((byte_i ^ main_addr) & CMP_MASK) == '0;
    hit_aux_o  = !single_i && (((byte_i ^ AUX_ADDR) & CMP_MASK) == '0) && !hit_main_o;
  end
endmodule

// File: rtl/dag_bank_map.sv
module dag_bank_map
  import dag_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] BANK_BASE = 8'h80,
  parameter logic [AW-1:0] TBL_EXT = 8'h00,
  parameter logic [AW-1:0] TBL_CFG = 8'h01,
  parameter logic [AW-1:0] TBL_LUT = 8'h02,
  parameter logic [AW-1:0] TBL_AUX = 8'h03
) (
  input  logic          sel_main_i,
  input  logic          single_i,
  input  logic [AW-1:0] tbl_i,
  input  logic [AW-1:0] addr_i,
  output rgn_e          region_o,
  output logic [AW-1:0] local_o,
  output logic          blank_o
);
  always_comb begin
    region_o = RGN_NONE;
    local_o  = addr_i;
    if (!sel_main_i) begin
      region_o = RGN_AUX;
    end else if (addr_i < BANK_BASE) begin
      region_o = RGN_MAIN_LO;
    end else begin
      local_o = addr_i - BANK_BASE;
      if (tbl_i == TBL_EXT)      region_o = single_i ? RGN_TBL0 : RGN_NONE;
      else if (tbl_i == TBL_CFG) region_o = RGN_TBL1;
      else if (tbl_i == TBL_LUT) region_o = RGN_TBL2;
      else if (tbl_i == TBL_AUX) region_o = RGN_AUX;
    end
    blank_o = (region_o == RGN_NONE);
  end
endmodule

// File: rtl/dag_wr_gate.sv
module dag_wr_gate
  import dag_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] VOL_LO = 8'h60,
  parameter logic [AW-1:0] VOL_HI = 8'h7F
) (
  input  logic          sel_main_i,
  input  rgn_e          region_i,
  input  logic [AW-1:0] addr_i,
  input  logic          aux_lock_i,
  input  logic          main_lock_i,
  input  logic          wp_i,
  output logic          allow_o,
  output logic          nonvol_o
);
  logic vol, main_ok;

  always_comb begin
    vol     = sel_main_i && addr_i >= VOL_LO && addr_i <= VOL_HI;
    main_ok = !(main_lock_i && wp_i);
    if (region_i == RGN_NONE)      allow_o = 1'b0;
    else if (vol)                  allow_o = 1'b1;
    else if (!sel_main_i)          allow_o = !aux_lock_i;
    else if (region_i == RGN_TBL0) allow_o = !aux_lock_i; // pin ignored
    else                           allow_o = main_ok;
    nonvol_o = !vol;
  end
endmodule

// File: rtl/dual_addr_guard.sv
module dual_addr_guard
  import dag_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] MAIN_DEF = 8'hA2,
  parameter logic [AW-1:0] AUX_ADDR = 8'hA0,
  parameter logic [AW-1:0] BANK_BASE = 8'h80,
  parameter logic [AW-1:0] VOL_LO = 8'h60,
  parameter logic [AW-1:0] VOL_HI = 8'h7F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_single_i,
  input  logic          cfg_fix_i,
  input  logic          cfg_aux_lock_i,
  input  logic          cfg_main_lock_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [AW-1:0] tbl_sel_i,
  input  logic          wp_i,
  input  logic          dev_stb_i,
  input  logic [AW-1:0] dev_byte_i,
  output logic          dev_ack_o,
  input  logic          stop_i,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] mem_addr_i,
  output logic          data_ack_o,
  output logic          wr_en_o,
  output logic [2:0]    region_o,
  output logic [AW-1:0] local_addr_o,
  output logic          blank_o,
  output logic          commit_o
);
  logic hit_main, hit_aux, allow, nonvol;
  logic active_q, sel_main_q, rd_q, pend_q, commit_q;
  rgn_e region;

  dag_dev_match #(.AW(AW), .MAIN_DEF(MAIN_DEF), .AUX_ADDR(AUX_ADDR)) u_match (
    .single_i(cfg_single_i), .fix_i(cfg_fix_i), .prog_i(prog_addr_i),
    .byte_i(dev_byte_i), .hit_main_o(hit_main), .hit_aux_o(hit_aux)
  );

  dag_bank_map #(.AW(AW), .BANK_BASE(BANK_BASE)) u_map (
    .sel_main_i(sel_main_q), .single_i(cfg_single_i), .tbl_i(tbl_sel_i),
    .addr_i(mem_addr_i), .region_o(region), .local_o(local_addr_o), .blank_o(blank_o)
  );

  dag_wr_gate #(.AW(AW), .VOL_LO(VOL_LO), .VOL_HI(VOL_HI)) u_gate (
    .sel_main_i(sel_main_q), .region_i(region), .addr_i(mem_addr_i),
    .aux_lock_i(cfg_aux_lock_i), .main_lock_i(cfg_main_lock_i), .wp_i(wp_i),
    .allow_o(allow), .nonvol_o(nonvol)
  );

  assign dev_ack_o  = dev_stb_i && (hit_main || hit_aux);
  assign data_ack_o = wr_stb_i && active_q && !rd_q;
  assign wr_en_o    = data_ack_o && allow;
  assign region_o   = region;
  assign commit_o   = commit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      sel_main_q <= 1'b1;
      rd_q       <= 1'b0;
      pend_q     <= 1'b0;
      commit_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (stop_i) begin
        active_q <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else if (dev_stb_i) begin
        active_q <= dev_ack_o;
        if (dev_ack_o) begin
          sel_main_q <= hit_main;
          rd_q       <= dev_byte_i[0];
        end
      end else if (wr_en_o && nonvol) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dag_chk.sv
module dag_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_single_i,
  input logic       cfg_fix_i,
  input logic       cfg_aux_lock_i,
  input logic       cfg_main_lock_i,
  input logic [7:0] prog_addr_i,
  input logic       wp_i,
  input logic       dev_stb_i,
  input logic [7:0] dev_byte_i,
  input logic       dev_ack_o,
  input logic       stop_i,
  input logic       wr_stb_i,
  input logic [7:0] mem_addr_i,
  input logic       data_ack_o,
  input logic       wr_en_o,
  input logic [2:0] region_o,
  input logic       blank_o,
  input logic       commit_o,
  input logic       active_q,
  input logic       sel_main_q,
  input logic       rd_q
);
  logic aux_byte, prog_aux, in_vol;
  assign aux_byte = ((dev_byte_i ^ 8'hA0) & 8'hFE) == 8'h00;
  assign prog_aux = ((prog_addr_i ^ 8'hA0) & 8'hFE) == 8'h00;
  assign in_vol   = mem_addr_i >= 8'h60 && mem_addr_i <= 8'h7F;

  AST_AUX_SILENT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_stb_i && cfg_single_i && aux_byte && !(cfg_fix_i && prog_aux)) |-> !dev_ack_o); // R2
  AST_AUX_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (!sel_main_q || region_o == 3'(dag_pkg::RGN_TBL0))) |-> !cfg_aux_lock_i); // R4
  AST_MAIN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && sel_main_q && region_o != 3'(dag_pkg::RGN_TBL0) && !in_vol)
      |-> !(cfg_main_lock_i && wp_i)); // R5
  AST_VOL_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && active_q && !rd_q && sel_main_q && in_vol) |-> wr_en_o); // R6
  AST_WR_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> data_ack_o); // R7
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_i)); // R8
  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R8
  AST_BLANK_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> !wr_en_o); // R9
endmodule

bind dual_addr_guard dag_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_single_i(cfg_single_i), .cfg_fix_i(cfg_fix_i),
  .cfg_aux_lock_i(cfg_aux_lock_i), .cfg_main_lock_i(cfg_main_lock_i),
  .prog_addr_i(prog_addr_i), .wp_i(wp_i), .dev_stb_i(dev_stb_i), .dev_byte_i(dev_byte_i),
  .dev_ack_o(dev_ack_o), .stop_i(stop_i), .wr_stb_i(wr_stb_i), .mem_addr_i(mem_addr_i),
  .data_ack_o(data_ack_o), .wr_en_o(wr_en_o), .region_o(region_o), .blank_o(blank_o),
  .commit_o(commit_o), .active_q(active_q), .sel_main_q(sel_main_q), .rd_q(rd_q)
);

// File: tb/dual_addr_guard_tb_top.sv
`timescale 1ns/1ps
module dual_addr_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single = 0, fix = 0, aux_lock = 0, main_lock = 0, wp = 0;
  logic [7:0] prog = 8'h00, tbl = 8'h01;
  logic dev_stb = 0, stop = 0, wr_stb = 0;
  logic [7:0] dev_byte = 8'h00, mem_addr = 8'h00;
  logic dev_ack, data_ack, wr_en, blank, commit;
  logic [2:0] region;
  logic [7:0] local_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_addr_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_single_i(single), .cfg_fix_i(fix),
    .cfg_aux_lock_i(aux_lock), .cfg_main_lock_i(main_lock), .prog_addr_i(prog),
    .tbl_sel_i(tbl), .wp_i(wp), .dev_stb_i(dev_stb), .dev_byte_i(dev_byte),
    .dev_ack_o(dev_ack), .stop_i(stop), .wr_stb_i(wr_stb), .mem_addr_i(mem_addr),
    .data_ack_o(data_ack), .wr_en_o(wr_en), .region_o(region),
    .local_addr_o(local_addr), .blank_o(blank), .commit_o(commit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dev_sel(input logic [7:0] b, output logic ack);
    @(negedge clk); dev_stb = 1; dev_byte = b;
    #2 ack = dev_ack;
    @(negedge clk); dev_stb = 0;
  endtask

  task automatic wr(input logic [7:0] a, output logic dack, output logic wen,
                    output logic [2:0] rg, output logic [7:0] la, output logic bl);
    @(negedge clk); wr_stb = 1; mem_addr = a;
    #2 dack = data_ack; wen = wr_en; rg = region; la = local_addr; bl = blank;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic end_tr(output logic cm);
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    #2 cm = commit;
  endtask

  task automatic t_reset();
    logic d, w, b; logic [2:0] r; logic [7:0] l;
    chk("R10 commit after reset", commit, 0);
    wr(8'h10, d, w, r, l, b);
    chk("R10 data ack idle", d, 0);
    chk("R10 wr_en idle", w, 0);
  endtask

  task automatic t_addr();
    logic a, c;
    single = 0; fix = 0;
    dev_sel(8'hA2, a); chk("R1 main default ack", a, 1); end_tr(c);
    dev_sel(8'hA3, a); chk("R1 main read ack", a, 1); end_tr(c);
    dev_sel(8'hA0, a); chk("R2 aux dual ack", a, 1); end_tr(c);
    dev_sel(8'hA6, a); chk("R1 foreign nack", a, 0);
    single = 1;
    dev_sel(8'hA0, a); chk("R2 aux single nack", a, 0);
    dev_sel(8'hA2, a); chk("R1 main single ack", a, 1); end_tr(c);
    single = 0; fix = 1; prog = 8'hB4;
    dev_sel(8'hB4, a); chk("R1 prog addr ack", a, 1); end_tr(c);
    dev_sel(8'hA2, a); chk("R1 default ignored when fixed", a, 0);
    fix = 0;
  endtask

  task automatic t_map();
    logic a, d, w, b, c; logic [2:0] r; logic [7:0] l;
    dev_sel(8'hA2, a);
    wr(8'h10, d, w, r, l, b);
    chk("R3 low region", r, 1); chk("R3 low local", l, 8'h10);
    tbl = 8'h01; wr(8'h85, d, w, r, l, b);
    chk("R3 tbl1 region", r, 4); chk("R3 tbl1 local", l, 8'h05);
    tbl = 8'h02; wr(8'h9A, d, w, r, l, b);
    chk("R3 tbl2 region", r, 5); chk("R3 tbl2 local", l, 8'h1A);
    tbl = 8'h03; wr(8'h85, d, w, r, l, b);
    chk("R3 tbl3 aux region", r, 2); chk("R3 tbl3 local", l, 8'h05);
    tbl = 8'h00; wr(8'h85, d, w, r, l, b);
    chk("R9 tbl0 dual blank", b, 1); chk("R9 tbl0 dual no wr", w, 0);
    chk("R7 blank write still acked", d, 1);
    tbl = 8'h07; wr(8'h85, d, w, r, l, b);
    chk("R9 tbl7 region", r, 0); chk("R9 tbl7 no wr", w, 0);
    end_tr(c);
    single = 1; tbl = 8'h00;
    dev_sel(8'hA2, a); wr(8'h85, d, w, r, l, b);
    chk("R3 tbl0 single region", r, 3); chk("R3 tbl0 single wr", w, 1);
    end_tr(c); single = 0;
    dev_sel(8'hA0, a); wr(8'hC3, d, w, r, l, b);
    chk("R4 aux region", r, 2); chk("R4 aux local", l, 8'hC3);
    end_tr(c); tbl = 8'h01;
  endtask

  task automatic t_protect();
    logic a, d, w, b, c; logic [2:0] r; logic [7:0] l;
    main_lock = 1; wp = 1;
    dev_sel(8'hA2, a);
    wr(8'h10, d, w, r, l, b);
    chk("R5 locked low no wr", w, 0); chk("R7 locked still acked", d, 1);
    tbl = 8'h02; wr(8'h90, d, w, r, l, b); chk("R5 locked tbl2", w, 0);
    wr(8'h65, d, w, r, l, b); chk("R6 vol 65 open", w, 1);
    wr(8'h7F, d, w, r, l, b); chk("R6 vol 7F open", w, 1);
    wp = 0; wr(8'h10, d, w, r, l, b); chk("R5 pin low unlocks", w, 1);
    end_tr(c);
    aux_lock = 1; main_lock = 0;
    dev_sel(8'hA0, a); wr(8'h20, d, w, r, l, b);
    chk("R4 aux locked", w, 0); chk("R7 aux locked acked", d, 1);
    end_tr(c);
    single = 1; tbl = 8'h00;
    dev_sel(8'hA2, a); wr(8'h80, d, w, r, l, b); chk("R4 tbl0 aux locked pin low", w, 0);
    end_tr(c);
    aux_lock = 0; main_lock = 1; wp = 1;
    dev_sel(8'hA2, a); wr(8'h80, d, w, r, l, b); chk("R4 tbl0 ignores pin", w, 1);
    end_tr(c);
    single = 0; main_lock = 0; wp = 0; tbl = 8'h01;
  endtask

  task automatic t_commit();
    logic a, d, w, b, c; logic [2:0] r; logic [7:0] l;
    dev_sel(8'hA2, a); wr(8'h20, d, w, r, l, b); end_tr(c);
    chk("R8 commit after nv write", c, 1);
    @(negedge clk); chk("R8 commit one cycle", commit, 0);
    dev_sel(8'hA2, a); wr(8'h70, d, w, r, l, b); end_tr(c);
    chk("R8 volatile no commit", c, 0);
    main_lock = 1; wp = 1;
    dev_sel(8'hA2, a); wr(8'h20, d, w, r, l, b); end_tr(c);
    chk("R8 refused no commit", c, 0);
    main_lock = 0; wp = 0;
    wr(8'h20, d, w, r, l, b); chk("R11 after stop no ack", d, 0);
    dev_sel(8'hA2, a); dev_sel(8'hA6, a);
    wr(8'h20, d, w, r, l, b); chk("R11 nacked byte ends tr", d, 0);
    dev_sel(8'hA3, a); wr(8'h20, d, w, r, l, b);
    chk("R7 read tr no ack", d, 0); chk("R7 read tr no wr", w, 0);
    end_tr(c);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_addr();
    t_map();
    t_protect();
    t_commit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule